// File: doc/BRIEF.md
# Pre-Add Dot Product Pipeline

The block is a streaming arithmetic engine. Every clock cycle it can accept one signed sample. For each sample it returns one signed result: a weighted sum across N taps. Tap i first adds its own fixed offset to the sample, then multiplies that sum by a coefficient, and the products of all taps are added together. The coefficient set is not constant. After every accepted sample it rotates by one position, so successive samples see successive rotations of the same coefficient ring.

The datapath is laid out as a systolic chain. The sample walks down a register line with one stage per tap, and each tap reads its stage, so no register drives more than two loads. The partial sum travels beside the sample through one register per tap, which forms an adder chain instead of an adder tree. Each tap keeps its own modulo-N phase counter, which advances only when a valid sample passes that tap. A tap therefore applies the coefficient that belonged to the sample in hand, even when the input has gaps.

The block has a valid-qualified input and a valid-qualified output. It has no backpressure. Results leave in input order, at a fixed latency.

Top module: `preadd_dot_chain`

## Requirements
- R1: For a sample v accepted as the n-th valid sample since reset (n counted from 0), result_o equals the sum over i = 0..N-1 of c[(i+n) mod N] * (v + ofs[i]). The sum is computed in DW-bit two's complement with wraparound.
- R2: The coefficient ring c[k] equals k+1 for k = 0..N-1. After N accepted samples the rotation returns to its starting phase, so sample n and sample n+N see the same coefficients.
- R3: The offset ofs[i] depends on which quarter of the tap range i falls in, with Q = N/4. For i < Q, ofs[i] = Q+1+i. For Q <= i < 2Q, ofs[i] = 2Q+1+i. For 2Q <= i < 3Q, ofs[i] = i+1. For i >= 3Q, ofs[i] = N-i. With N = 64 the four quarters are 17..32, 49..64, 33..48, and 16 down to 1.
- R4: Suppose valid_i is sampled high at rising edge e. Then valid_o is high, together with that sample's result, in the cycle that follows rising edge e+N+1. That is a latency of N+1 edges, or N+2 cycles when the input cycle is counted.
- R5: Samples presented on consecutive cycles are all accepted, with no bubbles. Each one produces one result on consecutive output cycles.
- R6: A cycle with valid_i low produces exactly one cycle with valid_o low at the same latency, and it does not advance the coefficient rotation.
- R7: While rst_ni is low, valid_o is low. After reset, samples in flight are discarded, and the next accepted sample uses rotation phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample on sample_i is valid this cycle |
| sample_i | input | DW | Signed input sample |
| valid_o | output | 1 | result_o holds a result this cycle |
| result_o | output | DW | Signed dot product result |

## Verification
The assertions take three things for granted:
- rst_ni is asserted before the first valid sample.
- valid_i always carries a known level.
- A tap's phase advances only in cycles where its stage holds a valid sample.

Arithmetic overflow is outside the assertions' concern, because the design wraps by definition. The bench keeps every sample between 0 and 1023, so its reference sum stays well inside the signed 32-bit range and a plain integer model matches exactly. Valid patterns mix unbroken runs longer than N, random gaps, long idle stretches and a reset with samples still in flight.

// File: rtl/preadd_dot_pkg.sv
package preadd_dot_pkg;

  // coefficient ring value at ring position k
  function automatic int unsigned coef_init(input int unsigned k);
    return k + 1;
  endfunction

  // per-tap offset, four quarter bands
  function automatic int unsigned ofs_init(input int unsigned k, input int unsigned n);
    int unsigned q;
    q = n / 4;
    if (k < q)          return q + 1 + k;
    else if (k < 2 * q) return 2 * q + 1 + k;
    else if (k < 3 * q) return k + 1;
    else                return n - k;
  endfunction

endpackage

// File: rtl/pdc_tap_phase.sv
module pdc_tap_phase #(
  parameter int unsigned N     = 64,
  parameter int unsigned START = 0,
  localparam int unsigned IW   = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [IW-1:0] idx_o
);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= IW'(START);
    else if (step_i) idx_q <= (idx_q == IW'(N - 1)) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

endmodule

// File: rtl/pdc_tap.sv
module pdc_tap
  import preadd_dot_pkg::*;
#(
  parameter int unsigned N    = 64,
  parameter int unsigned DW   = 32,
  parameter int unsigned TAP  = 0,
  localparam int unsigned IW  = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] acc_o,
  output logic [IW-1:0] idx_o
);

  localparam logic [DW-1:0] OFS = DW'(ofs_init(TAP, N));

  logic [IW-1:0] idx;
  logic [DW-1:0] coef, pre, term, acc_q;

  // phase starts at TAP: tap j meets sample n at ring position j+n
  pdc_tap_phase #(.N(N), .START(TAP)) i_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (vld_i),
    .idx_o  (idx)
  );

  assign coef = DW'(coef_init(32'(idx)));
  assign pre  = smp_i + OFS;
  assign term = coef * pre;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_i + term;
  end

  assign acc_o = acc_q;
  assign idx_o = idx;

endmodule

// File: rtl/preadd_dot_chain.sv
module preadd_dot_chain #(
  parameter int unsigned N    = 64,
  parameter int unsigned DW   = 32,
  localparam int unsigned IW  = $clog2(N),
  localparam int unsigned LAT = N + 1,
  localparam int unsigned CW  = $clog2(LAT + 2) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] sample_i,
  output logic          valid_o,
  output logic [DW-1:0] result_o
);

  logic [N:0]    vld_c;
  logic [DW-1:0] smp_c [N];
  logic [DW-1:0] acc_c [N+1];
  logic [IW-1:0] idx_c [N];
  logic          valid_q;
  logic [DW-1:0] res_q;

  // validity shift line, stage 0 is the input register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_c <= '0;
    else         vld_c <= {vld_c[N-1:0], valid_i};
  end

  // sample delay line, one stage per tap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) smp_c[k] <= '0;
    end else begin
      smp_c[0] <= sample_i;
      for (int k = 1; k < N; k++) smp_c[k] <= smp_c[k-1];
    end
  end

  assign acc_c[0] = '0;

  for (genvar j = 0; j < N; j++) begin : g_tap
    pdc_tap #(.N(N), .DW(DW), .TAP(j)) i_tap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (vld_c[j]),
      .smp_i  (smp_c[j]),
      .acc_i  (acc_c[j]),
      .acc_o  (acc_c[j+1]),
      .idx_o  (idx_c[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= vld_c[N];
      res_q   <= acc_c[N];
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;

  // samples accepted but not yet emitted
  logic [CW-1:0] infl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) infl_q <= '0;
    else         infl_q <= infl_q + CW'(valid_i) - CW'(valid_q);
  end

  AST_INFLIGHT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    infl_q <= CW'(LAT + 1)); // R4

  AST_OUT_HAS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> infl_q != '0); // R6

  AST_ROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_c[0] |=> $stable(idx_c[0])); // R6

  for (genvar j = 0; j < N - 1; j++) begin : g_chk
    AST_COEF_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_c[j+1] |-> idx_c[j+1] ==
        (($past(idx_c[j]) == IW'(N - 1)) ? '0 : $past(idx_c[j]) + 1'b1)); // R2
  end

endmodule

// File: tb/test_preadd_dot_chain.sv
module test_preadd_dot_chain;

  localparam int N   = 64;
  localparam int LAT = N + 1;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] sample_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  always #4 clk = ~clk;

  preadd_dot_chain #(.N(N), .DW(32)) i_preadd_dot_chain (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .sample_i (sample_i),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  int    checks = 0;
  int    fails  = 0;
  int    ncyc   = 0;
  int    mc [N];
  int    exp_q [$];
  int    due_q [$];
  string tag_q [$];
  string idle_tag = "R6";

  function automatic int off_ref(int i);
    if (i < 16)      return 17 + i;
    else if (i < 32) return 49 + (i - 16);
    else if (i < 48) return 33 + (i - 32);
    else             return 16 - (i - 48);
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) mc[i] = i + 1;
  endfunction

  function automatic void model_rotate();
    int tmp;
    tmp = mc[0];
    for (int i = 0; i < N - 1; i++) mc[i] = mc[i+1];
    mc[N-1] = tmp;
  endfunction

  function automatic int dot_ref(int v);
    int acc;
    acc = 0;
    for (int i = 0; i < N; i++) acc += mc[i] * (v + off_ref(i));
    return acc;
  endfunction

  task automatic check_out();
    if (due_q.size() > 0 && due_q[0] < ncyc) begin
      checks++; fails++;
      $display("FAIL R4 result due at edge %0d missing, actual valid_o=%0b expected 1", due_q[0], valid_o);
      void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end
    if (due_q.size() > 0 && due_q[0] == ncyc) begin
      checks++;
      if (valid_o !== 1'b1) begin
        fails++;
        $display("FAIL R4 edge %0d actual valid_o=%0b expected 1", ncyc, valid_o);
      end else if (int'(result_o) != exp_q[0]) begin
        fails++;
        $display("FAIL %s edge %0d actual %0d expected %0d", tag_q[0], ncyc, int'(result_o), exp_q[0]);
      end
      void'(due_q.pop_front()); void'(exp_q.pop_front()); void'(tag_q.pop_front());
    end else if (valid_o !== 1'b0) begin
      checks++; fails++;
      $display("FAIL %s edge %0d actual valid_o=%0b expected 0", idle_tag, ncyc, valid_o);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    ncyc++;
    check_out();
  endtask

  task automatic drive(bit en, int s, string tag);
    tick();
    valid_i  = en;
    sample_i = 32'(s);
    if (en) begin
      exp_q.push_back(dot_ref(s));
      due_q.push_back(ncyc + 1 + LAT);
      tag_q.push_back(tag);
      model_rotate();
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(1'b0, 0, "R6");
  endtask

  task automatic apply_reset();
    tick();
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    exp_q.delete(); due_q.delete(); tag_q.delete();
    model_reset();
    idle_tag = "R7";
    for (int k = 0; k < 3; k++) tick();
    rst_ni = 1'b1;
    tick();
    checks++;
    if (valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R7 after reset actual valid_o=%0b expected 0", valid_o);
    end
    idle_tag = "R6";
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    apply_reset();

    // R1 R3: zero sample isolates the offset table, phase 0
    drive(1'b1, 0, "R3");
    idle(LAT + 3);
    drive(1'b1, 1023, "R1");
    idle(LAT + 3);

    // R5 R2: unbroken run past one full rotation
    for (int k = 0; k < 2 * N + 7; k++) drive(1'b1, int'($urandom_range(1023, 0)), "R5");
    idle(5);

    // R6 R1: random gaps
    for (int k = 0; k < 2000; k++) begin
      if ($urandom_range(9, 0) < 6) drive(1'b1, int'($urandom_range(1023, 0)), "R1");
      else                          drive(1'b0, 0, "R6");
    end

    // R6: long gap then a burst with alternating extremes
    idle(LAT + 20);
    for (int k = 0; k < 12; k++) drive(1'b1, (k % 2 == 0) ? 1023 : 0, "R6");
    idle(3);

    // R2: exactly N samples then repeat the same value
    for (int k = 0; k < N; k++) drive(1'b1, 500, "R2");
    drive(1'b1, 500, "R2");
    idle(LAT + 3);

    // R7: reset with samples in flight
    for (int k = 0; k < 10; k++) drive(1'b1, int'($urandom_range(1023, 0)), "R7");
    apply_reset();
    idle(LAT + 3);
    drive(1'b1, 0, "R7");
    drive(1'b1, 777, "R7");
    idle(LAT + 5);

    summary();
    $finish;
  end

endmodule